// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It works through the multiplier one bit per clock with radix-2 Booth recoding. The multiplier operand is loaded into the low half of a combined product register, and that low half shifts right as the partial product grows into it. Alongside it are a separately held multiplicand, an accumulator for the high half and a single "previous bit" flag.

On every iteration the block looks at the lowest product bit and the previous bit as a pair:
- 01 adds the multiplicand into the high half.
- 10 subtracts the multiplicand from the high half.
- 00 and 11 leave the high half unchanged.

The whole register then shifts right arithmetically by one position, and the bit that falls off the bottom becomes the new previous bit.

A caller pulses `start_i` while the block is idle. It then waits for `done_o`, which stays high, together with a stable `product_o`, until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: A `start_i` sampled high at a rising edge while `busy_o` is low loads the operands. From the next cycle `busy_o` is 1 and `done_o` is 0.
- R3: `busy_o` stays high for exactly `WIDTH` cycles after the loading edge. `done_o` rises at the edge of the `WIDTH`-th iteration, so with the default of 32 it rises 32 clocks after the start edge.
- R4: When `done_o` is high, `product_o` equals the signed product of `mcand_i` and `mplier_i` as captured at the loading edge, encoded as `2*WIDTH`-bit two's complement. This holds for every combination of operand signs.
- R5: The extreme operands give exact results. Most-negative times most-negative gives 2^(2*WIDTH-2), and most-negative times -1 gives +2^(WIDTH-1), so the internal add/subtract step never wraps.
- R6: With `WIDTH` = 5, multiplicand 5 (5'b00101) times multiplier -3 (5'b11101) gives 10'b11_1111_0001, which is -15.
- R7: Once `done_o` is high, `done_o` and `product_o` hold their values until the next start is accepted, whatever the operand inputs do.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The running operation finishes at its original time with the product of its original operands.
- R9: `busy_o` and `done_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiply; honoured only while idle |
| mcand_i | input | WIDTH | Signed multiplicand, captured on an accepted start |
| mplier_i | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | High from completion until the next accepted start |
| product_o | output | 2*WIDTH | Signed product register contents |

## Verification
The hardest situation to reach is a subtraction of the most negative multiplicand. That case needs the extra accumulator bit, and it only shows up when that multiplicand meets a multiplier whose bit pattern opens a run of ones. The bench covers it in two ways. It sweeps every operand pair of a 5-bit instance, so each recoding pair meets each multiplicand, including -16. It also drives the 32-bit instance with directed extreme operands, followed by a block of pseudo-random pairs. A start collision in the middle of a run is forced on purpose, with different operands on the inputs, to show that the first operation finishes untouched and on time.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Action chosen by the two-bit recoding window
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_i,
    input  logic      prev_i,
    output booth_op_e op_o
);

    always_comb begin
        unique case ({cur_i, prev_i})
            2'b01:   op_o = OP_ADD;   // a run of ones just ended
            2'b10:   op_o = OP_SUB;   // a run of ones begins
            default: op_o = OP_NONE;  // inside a run or inside zeros
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic [WIDTH:0]   acc_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  booth_op_e        op_i,
    output logic [WIDTH:0]   sum_o
);

    localparam int AW = WIDTH + 1;

    logic [WIDTH:0] ext;
    assign ext = {mcand_i[WIDTH-1], mcand_i};

    generate
        if (SHARED_ADDER) begin : g_shared
            // one adder: invert the operand and inject a carry to subtract
            logic [WIDTH:0] opnd;
            logic           cin;
            always_comb begin
                opnd = '0;
                cin  = 1'b0;
                if (op_i == OP_ADD) begin
                    opnd = ext;
                end else if (op_i == OP_SUB) begin
                    opnd = ~ext;
                    cin  = 1'b1;
                end
            end
            assign sum_o = acc_i + opnd + AW'(cin);
        end else begin : g_dual
            // separate adder and subtractor, result selected afterwards
            logic [WIDTH:0] plus_w;
            logic [WIDTH:0] minus_w;
            assign plus_w  = acc_i + ext;
            assign minus_w = acc_i - ext;
            always_comb begin
                unique case (op_i)
                    OP_ADD:  sum_o = plus_w;
                    OP_SUB:  sum_o = minus_w;
                    default: sum_o = acc_i;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);

    localparam int            CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        logic [WIDTH:0]   acc;    // high half, one guard bit above it
        logic [WIDTH-1:0] lo;     // low half, starts out as the multiplier
        logic             prev;   // bit most recently shifted out
        logic [WIDTH-1:0] mcand;
        logic [CW-1:0]    cnt;
        logic             busy;
        logic             done;
    } state_t;

    state_t    state_d, state_q;
    booth_op_e op_w;
    logic [WIDTH:0] sum_w;

    booth_recode u_recode (
        .cur_i  (state_q.lo[0]),
        .prev_i (state_q.prev),
        .op_o   (op_w)
    );

    booth_addsub #(
        .WIDTH        (WIDTH),
        .SHARED_ADDER (SHARED_ADDER)
    ) u_addsub (
        .acc_i   (state_q.acc),
        .mcand_i (state_q.mcand),
        .op_i    (op_w),
        .sum_o   (sum_w)
    );

    always_comb begin
        state_d = state_q;
        if (!state_q.busy) begin
            if (start_i) begin
                state_d.acc   = '0;
                state_d.lo    = mplier_i;
                state_d.prev  = 1'b0;
                state_d.mcand = mcand_i;
                state_d.cnt   = '0;
                state_d.busy  = 1'b1;
                state_d.done  = 1'b0;
            end
        end else begin
            // arithmetic right shift of {sum, lo}
            state_d.acc  = {sum_w[WIDTH], sum_w[WIDTH:1]};
            state_d.lo   = {sum_w[0], state_q.lo[WIDTH-1:1]};
            state_d.prev = state_q.lo[0];
            state_d.cnt  = state_q.cnt + CW'(1);
            if (state_q.cnt == LAST) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o    = state_q.busy;
    assign done_o    = state_q.done;
    assign product_o = {state_q.acc[WIDTH-1:0], state_q.lo};

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int WIDTH = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               start_i,
    input logic [WIDTH-1:0]   mcand_i,
    input logic [WIDTH-1:0]   mplier_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [2*WIDTH-1:0] product_o
);

    localparam int RW = $clog2(WIDTH + 1) + 1;

    logic [WIDTH-1:0] a_q, b_q;
    logic [RW-1:0]    run_q;
    logic [2*WIDTH-1:0] ax_w, bx_w, ref_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a_q   <= '0;
            b_q   <= '0;
            run_q <= '0;
        end else if (start_i && !busy_o) begin
            a_q   <= mcand_i;
            b_q   <= mplier_i;
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + RW'(1);
        end
    end

    assign ax_w  = {{WIDTH{a_q[WIDTH-1]}}, a_q};
    assign bx_w  = {{WIDTH{b_q[WIDTH-1]}}, b_q};
    assign ref_w = ax_w * bx_w;

    assert_start_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (run_q == RW'(WIDTH)));

    assert_product_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (product_o == ref_w));

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> (done_o && $stable(product_o)));

    assert_ignore_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && run_q != RW'(WIDTH - 1)) |=> busy_o);

    assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.WIDTH(WIDTH)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/booth_seq_mul_tb_top.sv
module booth_seq_mul_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    // 32-bit instance
    logic        st_l = 1'b0;
    logic [31:0] a_l = '0, b_l = '0;
    logic        busy_l, done_l;
    logic [63:0] p_l;

    // 5-bit instance for the exhaustive sweep
    logic        st_s = 1'b0;
    logic [4:0]  a_s = '0, b_s = '0;
    logic        busy_s, done_s;
    logic [9:0]  p_s;

    booth_seq_mul #(.WIDTH(32)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st_l),
        .mcand_i(a_l), .mplier_i(b_l),
        .busy_o(busy_l), .done_o(done_l), .product_o(p_l)
    );

    booth_seq_mul #(.WIDTH(5), .SHARED_ADDER(1'b0)) dut_s (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st_s),
        .mcand_i(a_s), .mplier_i(b_s),
        .busy_o(busy_s), .done_o(done_s), .product_o(p_s)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one 32-bit multiply; collide forces a start in mid-run (R8)
    task automatic mul_l(input logic [31:0] a, input logic [31:0] b,
                         input bit collide, input string req);
        logic [63:0] exp;
        exp = 64'(longint'($signed(a)) * longint'($signed(b)));
        @(negedge clk);
        st_l = 1'b1; a_l = a; b_l = b;
        @(negedge clk);
        st_l = 1'b0;
        check(busy_l && !done_l, "R2 busy after start", {62'd0, busy_l, done_l}, 64'd2);
        for (int i = 0; i < 31; i++) begin
            @(negedge clk);
            st_l = collide && (i == 10);
            a_l  = ~a;
            b_l  = b ^ 32'h5A5A_0F0F;
        end
        check(busy_l && !done_l, "R3 still busy after 31 iterations",
              {62'd0, busy_l, done_l}, 64'd2);
        @(negedge clk);
        check(done_l && !busy_l, "R3 done after 32 iterations",
              {62'd0, busy_l, done_l}, 64'd1);
        check(p_l == exp, req, p_l, exp);
    endtask

    task automatic mul_s(input int a, input int b);
        logic [9:0] exp;
        exp = 10'(a * b);
        @(negedge clk);
        st_s = 1'b1; a_s = 5'(a); b_s = 5'(b);
        @(negedge clk);
        st_s = 1'b0;
        repeat (5) @(negedge clk);
        check(done_s && (p_s == exp), "R4 5-bit sweep product",
              {53'd0, done_s, p_s}, {53'd0, 1'b1, exp});
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_l && !done_l && p_l == 64'd0, "R1 reset state 32-bit",
              p_l | {62'd0, busy_l, done_l}, 64'd0);
        check(!busy_s && !done_s && p_s == 10'd0, "R1 reset state 5-bit",
              {52'd0, busy_s, done_s, p_s}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: worked example
        mul_s(5, -3);
        check(p_s == 10'b11_1111_0001, "R6 5 x -3", {54'd0, p_s}, 64'h3F1);

        // R4/R5: exhaustive 5-bit sweep incl. -16 x -16
        for (int a = -16; a < 16; a++) begin
            for (int b = -16; b < 16; b++) begin
                mul_s(a, b);
            end
        end

        // R5: extremes on the 32-bit instance
        mul_l(32'h8000_0000, 32'h8000_0000, 1'b0, "R5 minint x minint");
        check(p_l == 64'h4000_0000_0000_0000, "R5 minint squared constant",
              p_l, 64'h4000_0000_0000_0000);
        mul_l(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R5 minint x -1");
        check(p_l == 64'h0000_0000_8000_0000, "R5 minint x -1 constant",
              p_l, 64'h0000_0000_8000_0000);
        mul_l(32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "R5 maxint x minint");
        mul_l(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, "R5 maxint x maxint");
        mul_l(32'h0000_0000, 32'h8000_0000, 1'b0, "R5 zero x minint");
        mul_l(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5 -1 x -1");
        mul_l(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R4 alternating bits");

        // R7: result held while inputs wander
        held = p_l;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            a_l = 32'(i * 977);
            b_l = 32'(i * 31);
        end
        check(done_l && p_l == held, "R7 result held", p_l, held);

        // R8: start collision mid-run
        mul_l(32'hFFFF_FF85, 32'h0001_2345, 1'b1, "R8 collision keeps first operands");
        mul_l(32'h8000_0000, 32'h8000_0001, 1'b1, "R8 collision extreme operands");

        // R4: pseudo-random signed pairs
        for (int i = 0; i < 300; i++) begin
            mul_l($urandom, $urandom, 1'b0, "R4 random pair");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule